// File: doc/BRIEF.md
# OUT Endpoint Interrupt Status Hierarchy

This block keeps the interrupt status of the OUT endpoints of a full-speed USB device controller. The protocol engine sends it single-cycle event pulses for each endpoint: transfer finished, endpoint disabled on request, SETUP packet received, SETUP stage ended, some other (non-SETUP) token seen, and OUT token arrived while the endpoint was disabled. Each pulse sets a sticky flag in that endpoint's status word. Each endpoint's flags are ORed into one bit of a per-endpoint summary vector, and that vector is ORed into a single OUT-endpoint interrupt line.

On control endpoints a small tracker follows the SETUP traffic. It counts consecutive SETUP packets and raises a flag when more than three arrive in a row. It also reports that the SETUP stage is done once the stage ends with no further SETUP packet arriving. Software reads the status words and the summary vector through a simple register port. It clears flags by writing ones to them. Clearing a flag takes effect at the same time in the summary bit and in the interrupt line.

Top module: `oep_irq_hier`

## Requirements
- R1: After reset, every endpoint status word reads 0x00000080, the summary register reads 0 and `oep_irq` is low.
- R2: A pulse on `ev_xfer_done[n]` sets bit 0, and a pulse on `ev_ep_dis[n]` sets bit 1, of endpoint n's status word (address 0xB08 + 0x20·n). Both are visible from the clock edge that samples the pulse. This holds for every endpoint.
- R3: Writing a 1 to a flag bit (0, 1, 3, 4, 6) clears it, and writing 0 leaves it unchanged. Bits 2, 5 and 31:8 always read 0 and bit 7 always reads 1, whatever is written.
- R4: If an event pulse and a write of 1 reach the same flag in the same cycle, the flag ends up set.
- R5: Bit n of the summary register (address 0x81C, bits 3:0, other bits read 0) is the OR of endpoint n's flags. `ep_summary` carries the same value. `oep_irq` is the OR of the summary bits. Clearing the flags drops both on the following cycle. Writes to the summary register are ignored.
- R6: On a control endpoint, the fourth SETUP packet in a row sets bit 6. The first three do not set it.
- R7: The consecutive-SETUP count returns to zero on `ev_tok_other`. It saturates at four, so further SETUP packets do not set bit 6 again until a non-SETUP token has been seen.
- R8: Bit 3 is set by `ev_setup_end` on a control endpoint that has received at least one SETUP packet since its last stage end or non-SETUP token, provided no SETUP packet arrives in the same cycle. Otherwise the end pulse is ignored.
- R9: `ev_tok_while_dis` sets bit 4 only on control endpoints (`CTRL_EP_MASK`, default endpoint 0 only). On other endpoints it has no effect.
- R10: On endpoints that are not control endpoints, SETUP packet and SETUP end pulses never set bits 3 or 6.
- R11: Addresses that are neither a status word nor the summary register read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_xfer_done | input | NUM_EP | Transfer-complete pulse per endpoint |
| ev_ep_dis | input | NUM_EP | Endpoint-disabled-on-request pulse per endpoint |
| ev_setup_pkt | input | NUM_EP | SETUP packet received pulse per endpoint |
| ev_setup_end | input | NUM_EP | SETUP stage ended pulse per endpoint |
| ev_tok_other | input | NUM_EP | Non-SETUP token seen pulse per endpoint |
| ev_tok_while_dis | input | NUM_EP | OUT token received while endpoint disabled |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe (write-one-to-clear) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| ep_summary | output | NUM_EP | Per-endpoint summary of pending flags |
| oep_irq | output | 1 | Global OUT-endpoint interrupt |

## Verification
A wrong tracker state shows up at the status word of the affected control endpoint within one SETUP or stage-end pulse. Either bit 6 appears on the wrong packet of a run, or bit 3 appears without a pending SETUP, or bit 3 is missing after one. A stuck or lost flag is seen at the next read of its word, and in `ep_summary` and `oep_irq` in the same cycle. Bad clear logic shows on the read right after the write. The vectors run saturation, counter restart, same-cycle set-and-clear and non-control endpoints through those reads.

// File: rtl/oep_irq_pkg.sv
package oep_irq_pkg;

    // Flag bit positions within an endpoint status word
    localparam int FLG_XFER   = 0;
    localparam int FLG_EPDIS  = 1;
    localparam int FLG_STUP   = 3;
    localparam int FLG_TOKDIS = 4;
    localparam int FLG_B2B    = 6;

    localparam int FLG_W = 7;

    typedef logic [FLG_W-1:0] oep_flags_t;

    // Writable / settable flag bits
    localparam oep_flags_t FLAG_MASK = oep_flags_t'((1 << FLG_XFER) | (1 << FLG_EPDIS) |
                                                    (1 << FLG_STUP) | (1 << FLG_TOKDIS) |
                                                    (1 << FLG_B2B));

    // Reserved bit that reads as one
    localparam int RSV_ONE_BIT = 7;

    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,   // no SETUP stage pending
        TRK_SETUP = 2'd1,   // SETUP packets received, run below the limit
        TRK_B2B   = 2'd2    // run went past the limit
    } trk_state_e;

endpackage

// File: rtl/oep_setup_tracker.sv
module oep_setup_tracker #(
    parameter int B2B_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic setup_pkt,
    input  logic setup_end,
    input  logic tok_other,
    output logic b2b_hit,
    output logic stup_hit
);
    import oep_irq_pkg::*;

    localparam int CNT_MAX = B2B_LIMIT + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    trk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;

    // Count base: a non-SETUP token restarts the run
    always_comb begin
        cnt_base = tok_other ? '0 : cnt_q;
    end

    // Next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_base;
        if (setup_pkt && (cnt_base != CNT_W'(CNT_MAX))) begin
            cnt_d = cnt_base + 1'b1;
        end
        unique case (state_q)
            TRK_IDLE: begin
                if (setup_pkt) begin
                    state_d = (cnt_base == CNT_W'(B2B_LIMIT)) ? TRK_B2B : TRK_SETUP;
                end
            end
            TRK_SETUP: begin
                if (setup_pkt) begin
                    state_d = (cnt_base == CNT_W'(B2B_LIMIT)) ? TRK_B2B : TRK_SETUP;
                end else if (setup_end || tok_other) begin
                    state_d = TRK_IDLE;
                end
            end
            TRK_B2B: begin
                if (!setup_pkt && (setup_end || tok_other)) begin
                    state_d = TRK_IDLE;
                end
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        b2b_hit  = setup_pkt && (cnt_base == CNT_W'(B2B_LIMIT));
        stup_hit = setup_end && !setup_pkt && (state_q != TRK_IDLE);
    end

endmodule

// File: rtl/oep_flag_reg.sv
module oep_flag_reg (
    input  logic                     clk,
    input  logic                     rst_n,
    input  oep_irq_pkg::oep_flags_t  set_vec,
    input  oep_irq_pkg::oep_flags_t  clr_vec,
    output oep_irq_pkg::oep_flags_t  flags
);
    import oep_irq_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            // set has priority over clear
            flags <= ((flags & ~clr_vec) | set_vec) & FLAG_MASK;
        end
    end

endmodule

// File: rtl/oep_reg_port.sv
module oep_reg_port #(
    parameter int                NUM_EP    = 4,
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] EP_BASE   = 12'hB08,
    parameter logic [ADDR_W-1:0] EP_STRIDE = 12'h020,
    parameter logic [ADDR_W-1:0] SUM_ADDR  = 12'h81C
) (
    input  logic [ADDR_W-1:0]                       reg_addr,
    input  logic                                    reg_wr,
    input  logic [DATA_W-1:0]                       reg_wdata,
    input  logic [NUM_EP-1:0][oep_irq_pkg::FLG_W-1:0] flags,
    input  logic [NUM_EP-1:0]                       summary,
    output logic [NUM_EP-1:0][oep_irq_pkg::FLG_W-1:0] clr_vec,
    output logic [DATA_W-1:0]                       reg_rdata
);
    import oep_irq_pkg::*;

    logic [NUM_EP-1:0] ep_hit;
    logic              sum_hit;

    for (genvar n = 0; n < NUM_EP; n++) begin : g_dec
        assign ep_hit[n]  = (reg_addr == ADDR_W'(EP_BASE + EP_STRIDE * n));
        assign clr_vec[n] = (reg_wr && ep_hit[n]) ? (reg_wdata[FLG_W-1:0] & FLAG_MASK) : '0;
    end

    assign sum_hit = (reg_addr == SUM_ADDR);

    always_comb begin
        reg_rdata = '0;
        for (int n = 0; n < NUM_EP; n++) begin
            if (ep_hit[n]) begin
                reg_rdata                = DATA_W'(flags[n]);
                reg_rdata[RSV_ONE_BIT]   = 1'b1;
            end
        end
        if (sum_hit) begin
            reg_rdata = DATA_W'(summary);
        end
    end

endmodule

// File: rtl/oep_irq_hier.sv
module oep_irq_hier #(
    parameter int                NUM_EP       = 4,
    parameter int                ADDR_W       = 12,
    parameter int                DATA_W       = 32,
    parameter logic [ADDR_W-1:0] EP_BASE      = 12'hB08,
    parameter logic [ADDR_W-1:0] EP_STRIDE    = 12'h020,
    parameter logic [ADDR_W-1:0] SUM_ADDR     = 12'h81C,
    parameter logic [NUM_EP-1:0] CTRL_EP_MASK = 4'b0001,
    parameter int                B2B_LIMIT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] ev_xfer_done,
    input  logic [NUM_EP-1:0] ev_ep_dis,
    input  logic [NUM_EP-1:0] ev_setup_pkt,
    input  logic [NUM_EP-1:0] ev_setup_end,
    input  logic [NUM_EP-1:0] ev_tok_other,
    input  logic [NUM_EP-1:0] ev_tok_while_dis,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_EP-1:0] ep_summary,
    output logic              oep_irq
);
    import oep_irq_pkg::*;

    logic [NUM_EP-1:0][FLG_W-1:0] ep_flags;
    logic [NUM_EP-1:0][FLG_W-1:0] ep_set;
    logic [NUM_EP-1:0][FLG_W-1:0] ep_clr;

    for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
        logic b2b_hit;
        logic stup_hit;
        logic tokdis_hit;

        if (CTRL_EP_MASK[n]) begin : g_ctrl
            oep_setup_tracker #(
                .B2B_LIMIT (B2B_LIMIT)
            ) u_trk (
                .clk       (clk),
                .rst_n     (rst_n),
                .setup_pkt (ev_setup_pkt[n]),
                .setup_end (ev_setup_end[n]),
                .tok_other (ev_tok_other[n]),
                .b2b_hit   (b2b_hit),
                .stup_hit  (stup_hit)
            );
            assign tokdis_hit = ev_tok_while_dis[n];
        end else begin : g_data
            assign b2b_hit    = 1'b0;
            assign stup_hit   = 1'b0;
            assign tokdis_hit = 1'b0;
        end

        always_comb begin
            ep_set[n]             = '0;
            ep_set[n][FLG_XFER]   = ev_xfer_done[n];
            ep_set[n][FLG_EPDIS]  = ev_ep_dis[n];
            ep_set[n][FLG_STUP]   = stup_hit;
            ep_set[n][FLG_TOKDIS] = tokdis_hit;
            ep_set[n][FLG_B2B]    = b2b_hit;
        end

        oep_flag_reg u_flags (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vec (ep_set[n]),
            .clr_vec (ep_clr[n]),
            .flags   (ep_flags[n])
        );

        assign ep_summary[n] = |ep_flags[n];
    end

    assign oep_irq = |ep_summary;

    oep_reg_port #(
        .NUM_EP    (NUM_EP),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .EP_BASE   (EP_BASE),
        .EP_STRIDE (EP_STRIDE),
        .SUM_ADDR  (SUM_ADDR)
    ) u_port (
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .flags     (ep_flags),
        .summary   (ep_summary),
        .clr_vec   (ep_clr),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: rtl/oep_irq_hier_chk.sv
module oep_irq_hier_chk #(
    parameter int                NUM_EP       = 4,
    parameter int                ADDR_W       = 12,
    parameter int                DATA_W       = 32,
    parameter logic [ADDR_W-1:0] EP_BASE      = 12'hB08,
    parameter logic [ADDR_W-1:0] EP_STRIDE    = 12'h020,
    parameter logic [NUM_EP-1:0] CTRL_EP_MASK = 4'b0001
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_EP-1:0]       ev_xfer_done,
    input logic                    reg_wr,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic [DATA_W-1:0]       reg_wdata,
    input logic [DATA_W-1:0]       reg_rdata,
    input logic [NUM_EP-1:0]       ep_summary,
    input logic                    oep_irq,
    input logic [NUM_EP-1:0][6:0]  ep_flags
);

    AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        oep_irq == (ep_flags != '0)); // R5

    for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
        localparam logic [ADDR_W-1:0] A = ADDR_W'(EP_BASE + EP_STRIDE * n);

        AST_XFER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            ev_xfer_done[n] |=> ep_summary[n]); // R2

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_xfer_done[n] && reg_wr && reg_addr == A && reg_wdata[0]) |=> ep_flags[n][0]); // R4

        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (!ev_xfer_done[n] && reg_wr && reg_addr == A && reg_wdata[0]) |=> !ep_flags[n][0]); // R3

        AST_RESERVED_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == A) |-> (reg_rdata[DATA_W-1:7] == 1 && !reg_rdata[5] && !reg_rdata[2])); // R3

        if (!CTRL_EP_MASK[n]) begin : g_data
            AST_NONCTRL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                !ep_flags[n][6] && !ep_flags[n][4] && !ep_flags[n][3]); // R10
        end
    end

endmodule

bind oep_irq_hier oep_irq_hier_chk #(
    .NUM_EP       (NUM_EP),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .EP_BASE      (EP_BASE),
    .EP_STRIDE    (EP_STRIDE),
    .CTRL_EP_MASK (CTRL_EP_MASK)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_xfer_done (ev_xfer_done),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .ep_summary   (ep_summary),
    .oep_irq      (oep_irq),
    .ep_flags     (ep_flags)
);

// File: tb/oep_irq_hier_test.sv
module oep_irq_hier_test;

    localparam int OP_EV = 0, OP_WR = 1, OP_RD = 2, OP_IRQ = 3, OP_EVW = 4;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [1:0]  ep;
        logic [5:0]  ev;    // [0]xfer [1]dis [2]setup [3]end [4]other [5]tokdis
        logic [11:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int N = 75;
    localparam vec_t VEC [0:N-1] = '{
        '{4'd1, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'h80},        // R1
        '{4'd1, 3'(OP_RD),  2'd0, 6'h00, 12'h81C, 32'h0},         // R1
        '{4'd1, 3'(OP_IRQ), 2'd0, 6'h00, 12'h000, 32'h0},         // R1
        '{4'd2, 3'(OP_EV),  2'd1, 6'h01, 12'h000, 32'h0},
        '{4'd2, 3'(OP_RD),  2'd0, 6'h00, 12'hB28, 32'h81},        // R2
        '{4'd5, 3'(OP_RD),  2'd0, 6'h00, 12'h81C, 32'h2},         // R5
        '{4'd5, 3'(OP_IRQ), 2'd0, 6'h00, 12'h000, 32'h1},         // R5
        '{4'd2, 3'(OP_EV),  2'd1, 6'h02, 12'h000, 32'h0},
        '{4'd2, 3'(OP_RD),  2'd0, 6'h00, 12'hB28, 32'h83},        // R2
        '{4'd3, 3'(OP_WR),  2'd0, 6'h00, 12'hB28, 32'h1},
        '{4'd3, 3'(OP_RD),  2'd0, 6'h00, 12'hB28, 32'h82},        // R3
        '{4'd3, 3'(OP_WR),  2'd0, 6'h00, 12'hB28, 32'h0},
        '{4'd3, 3'(OP_RD),  2'd0, 6'h00, 12'hB28, 32'h82},        // R3
        '{4'd3, 3'(OP_WR),  2'd0, 6'h00, 12'hB28, 32'hFFFFFFFF},
        '{4'd3, 3'(OP_RD),  2'd0, 6'h00, 12'hB28, 32'h80},        // R3
        '{4'd5, 3'(OP_RD),  2'd0, 6'h00, 12'h81C, 32'h0},         // R5
        '{4'd5, 3'(OP_IRQ), 2'd0, 6'h00, 12'h000, 32'h0},         // R5
        '{4'd6, 3'(OP_EV),  2'd0, 6'h04, 12'h000, 32'h0},
        '{4'd6, 3'(OP_EV),  2'd0, 6'h04, 12'h000, 32'h0},
        '{4'd6, 3'(OP_EV),  2'd0, 6'h04, 12'h000, 32'h0},
        '{4'd6, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'h80},        // R6
        '{4'd6, 3'(OP_EV),  2'd0, 6'h04, 12'h000, 32'h0},
        '{4'd6, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'hC0},        // R6
        '{4'd8, 3'(OP_EV),  2'd0, 6'h08, 12'h000, 32'h0},
        '{4'd8, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'hC8},        // R8
        '{4'd3, 3'(OP_WR),  2'd0, 6'h00, 12'hB08, 32'hFF},
        '{4'd3, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'h80},        // R3
        '{4'd7, 3'(OP_EV),  2'd0, 6'h04, 12'h000, 32'h0},
        '{4'd7, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'h80},        // R7 saturated
        '{4'd8, 3'(OP_EV),  2'd0, 6'h08, 12'h000, 32'h0},
        '{4'd8, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'h88},        // R8
        '{4'd3, 3'(OP_WR),  2'd0, 6'h00, 12'hB08, 32'hFF},
        '{4'd7, 3'(OP_EV),  2'd0, 6'h10, 12'h000, 32'h0},
        '{4'd7, 3'(OP_EV),  2'd0, 6'h04, 12'h000, 32'h0},
        '{4'd7, 3'(OP_EV),  2'd0, 6'h04, 12'h000, 32'h0},
        '{4'd7, 3'(OP_EV),  2'd0, 6'h04, 12'h000, 32'h0},
        '{4'd7, 3'(OP_EV),  2'd0, 6'h04, 12'h000, 32'h0},
        '{4'd7, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'hC0},        // R7 restart
        '{4'd3, 3'(OP_WR),  2'd0, 6'h00, 12'hB08, 32'hFF},
        '{4'd8, 3'(OP_EV),  2'd0, 6'h08, 12'h000, 32'h0},
        '{4'd8, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'h88},        // R8
        '{4'd3, 3'(OP_WR),  2'd0, 6'h00, 12'hB08, 32'hFF},
        '{4'd8, 3'(OP_EV),  2'd0, 6'h08, 12'h000, 32'h0},
        '{4'd8, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'h80},        // R8 no pending
        '{4'd8, 3'(OP_EV),  2'd0, 6'h0C, 12'h000, 32'h0},
        '{4'd8, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'h80},        // R8 same-cycle SETUP
        '{4'd8, 3'(OP_EV),  2'd0, 6'h08, 12'h000, 32'h0},
        '{4'd8, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'h88},        // R8
        '{4'd3, 3'(OP_WR),  2'd0, 6'h00, 12'hB08, 32'hFF},
        '{4'd9, 3'(OP_EV),  2'd0, 6'h20, 12'h000, 32'h0},
        '{4'd9, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'h90},        // R9
        '{4'd3, 3'(OP_WR),  2'd0, 6'h00, 12'hB08, 32'hFF},
        '{4'd9, 3'(OP_EV),  2'd2, 6'h20, 12'h000, 32'h0},
        '{4'd9, 3'(OP_RD),  2'd0, 6'h00, 12'hB48, 32'h80},        // R9 data ep
        '{4'd10, 3'(OP_EV), 2'd2, 6'h04, 12'h000, 32'h0},
        '{4'd10, 3'(OP_EV), 2'd2, 6'h04, 12'h000, 32'h0},
        '{4'd10, 3'(OP_EV), 2'd2, 6'h04, 12'h000, 32'h0},
        '{4'd10, 3'(OP_EV), 2'd2, 6'h04, 12'h000, 32'h0},
        '{4'd10, 3'(OP_EV), 2'd2, 6'h08, 12'h000, 32'h0},
        '{4'd10, 3'(OP_RD), 2'd0, 6'h00, 12'hB48, 32'h80},        // R10
        '{4'd10, 3'(OP_RD), 2'd0, 6'h00, 12'h81C, 32'h0},         // R10
        '{4'd11, 3'(OP_WR), 2'd0, 6'h00, 12'hB0C, 32'hFFFFFFFF},
        '{4'd11, 3'(OP_RD), 2'd0, 6'h00, 12'hB0C, 32'h0},         // R11
        '{4'd11, 3'(OP_RD), 2'd0, 6'h00, 12'hB10, 32'h0},         // R11
        '{4'd2, 3'(OP_EV),  2'd3, 6'h01, 12'h000, 32'h0},
        '{4'd5, 3'(OP_WR),  2'd0, 6'h00, 12'h81C, 32'hFFFFFFFF},
        '{4'd5, 3'(OP_RD),  2'd0, 6'h00, 12'h81C, 32'h8},         // R5 write ignored
        '{4'd2, 3'(OP_RD),  2'd0, 6'h00, 12'hB68, 32'h81},        // R2
        '{4'd5, 3'(OP_IRQ), 2'd0, 6'h00, 12'h000, 32'h1},         // R5
        '{4'd4, 3'(OP_EVW), 2'd0, 6'h01, 12'hB08, 32'h1},
        '{4'd4, 3'(OP_RD),  2'd0, 6'h00, 12'hB08, 32'h81},        // R4
        '{4'd5, 3'(OP_RD),  2'd0, 6'h00, 12'h81C, 32'h9},         // R5
        '{4'd3, 3'(OP_WR),  2'd0, 6'h00, 12'hB68, 32'hFF},
        '{4'd3, 3'(OP_WR),  2'd0, 6'h00, 12'hB08, 32'hFF},
        '{4'd5, 3'(OP_IRQ), 2'd0, 6'h00, 12'h000, 32'h0}          // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ev_xfer_done = '0, ev_ep_dis = '0, ev_setup_pkt = '0;
    logic [3:0]  ev_setup_end = '0, ev_tok_other = '0, ev_tok_while_dis = '0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  ep_summary;
    logic        oep_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;   // 50 MHz

    oep_irq_hier uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .ev_xfer_done     (ev_xfer_done),
        .ev_ep_dis        (ev_ep_dis),
        .ev_setup_pkt     (ev_setup_pkt),
        .ev_setup_end     (ev_setup_end),
        .ev_tok_other     (ev_tok_other),
        .ev_tok_while_dis (ev_tok_while_dis),
        .reg_addr         (reg_addr),
        .reg_wr           (reg_wr),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .ep_summary       (ep_summary),
        .oep_irq          (oep_irq)
    );

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        ev_xfer_done = '0; ev_ep_dis = '0; ev_setup_pkt = '0;
        ev_setup_end = '0; ev_tok_other = '0; ev_tok_while_dis = '0;
        reg_wr = 1'b0; reg_wdata = '0; reg_addr = '0;
    endtask

    task automatic read_chk(input int req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        idle_inputs();
        reg_addr = a;
        #2;
        check(req, reg_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < N; i++) begin
            vec_t v;
            v = VEC[i];
            @(negedge clk);
            idle_inputs();
            case (int'(v.op))
                OP_EV, OP_EVW: begin
                    ev_xfer_done[v.ep]     = v.ev[0];
                    ev_ep_dis[v.ep]        = v.ev[1];
                    ev_setup_pkt[v.ep]     = v.ev[2];
                    ev_setup_end[v.ep]     = v.ev[3];
                    ev_tok_other[v.ep]     = v.ev[4];
                    ev_tok_while_dis[v.ep] = v.ev[5];
                    if (int'(v.op) == OP_EVW) begin
                        reg_wr    = 1'b1;
                        reg_addr  = v.addr;
                        reg_wdata = v.data;
                    end
                end
                OP_WR: begin
                    reg_wr    = 1'b1;
                    reg_addr  = v.addr;
                    reg_wdata = v.data;
                end
                OP_RD: begin
                    reg_addr = v.addr;
                    #2;
                    check(int'(v.req), reg_rdata, v.data);
                end
                OP_IRQ: begin
                    #2;
                    check(int'(v.req), {31'b0, oep_irq}, v.data);
                end
                default: ;
            endcase
        end

        // Directed: mid-run reset restores reset values (R1)
        @(negedge clk);
        idle_inputs();
        ev_xfer_done[2] = 1'b1;
        ev_ep_dis[0]    = 1'b1;
        read_chk(2, 12'hB48, 32'h81);      // R2 on endpoint 2
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_chk(1, 12'hB48, 32'h80);      // R1
        read_chk(1, 12'hB08, 32'h80);      // R1
        read_chk(1, 12'h81C, 32'h0);       // R1
        #2;
        check(1, {31'b0, oep_irq}, 32'h0); // R1
        check(5, {28'b0, ep_summary}, 32'h0); // R5

        // Directed: counter restart after reset, three SETUPs do not set bit 6 (R6)
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            idle_inputs();
            ev_setup_pkt[0] = 1'b1;
        end
        read_chk(6, 12'hB08, 32'h80);      // R6

        finish_run();
    end

endmodule